// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns it into characters. A tick generator divides the system clock to sixteen ticks per bit. The frame decoder uses those ticks to find each start bit, confirm it, and take a majority vote near the centre of every bit. Each accepted character goes into a two-entry receive queue. Each queue entry holds the eight data bits, the ninth bit and a framing-error bit. A ready flag, and an interrupt request gated by an enable, tell the host that a character is waiting.

For multidrop buses the receiver can take nine-bit characters. It can also filter them, so that only characters with the ninth bit set reach the queue. A node therefore sees only address characters until software lifts the filter. After an overrun the receiver locks out further characters. Software clears the lockout by dropping the receive enable for at least one clock.

Top module: `uart_mdrop_rx`

## Requirements
- R1: After reset, rxReady, irq and overrunErr are all 0.
- R2: A frame is one low start bit, then the data bits least-significant first, then one stop bit. In 8-bit mode the character appears on rdData with rdBit9 = 0. One bit lasts sixteen sample ticks.
- R3: One sample tick lasts (divisor+1)×M clocks. M is 16 when speedSel = 0, 4 when speedSel = 1, and 1 when speedSel = 2 or 3. One bit is therefore (divisor+1)×256, ×64 or ×16 clocks.
- R4: When nineBitMode = 1, nine data bits are received. The ninth bit is reported on rdBit9 with its character.
- R5: When nineBitMode = 1 and addrDetEn = 1, a character whose ninth bit is 0 is discarded and one whose ninth bit is 1 is queued. When addrDetEn = 0, every character is queued.
- R6: A character whose stop bit is voted 0 is queued with rdFerr = 1. A character with a good stop bit has rdFerr = 0.
- R7: The queue holds two characters in arrival order. rxReady is 1 while the queue is not empty. A one-cycle pulse on rdStrobe removes the character shown on rdData, rdBit9 and rdFerr.
- R8: A character that completes while the queue is full sets overrunErr and is dropped. While overrunErr = 1, every later character is dropped and the queue keeps its contents.
- R9: rxEn = 0 clears overrunErr. Characters are received only while both portEn and rxEn are 1.
- R10: irq equals rxReady when irqEn = 1 and is 0 when irqEn = 0.
- R11: A low pulse on the line that has ended before the start bit's centre is rejected, and no character results. Each bit value is the majority of three consecutive samples at the bit centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input, idle high |
| portEn | input | 1 | Serial port enable |
| rxEn | input | 1 | Receive enable; low clears overrun |
| nineBitMode | input | 1 | 1 selects nine data bits |
| addrDetEn | input | 1 | Address filter enable (nine-bit mode) |
| divisor | input | DIV_W | Baud divisor, tick = (divisor+1)×M clocks |
| speedSel | input | 2 | Prescale select: 0 → M=16, 1 → M=4, 2/3 → M=1 |
| irqEn | input | 1 | Interrupt enable |
| rdStrobe | input | 1 | Pop the head character |
| rdData | output | 8 | Head character data |
| rdBit9 | output | 1 | Head character ninth bit |
| rdFerr | output | 1 | Head character framing error |
| overrunErr | output | 1 | Overrun lockout flag |
| rxReady | output | 1 | Queue not empty |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the default DIV_W = 8 and queue depth of two. A depth of two lets three back-to-back frames show the full, overrun and lockout cases. Most frames run at speedSel = 2 with divisor = 1, which gives 32-clock bits so that many frames fit in a short run. Single frames at speedSel = 1 and speedSel = 0 check the other prescale factors. The bench's behavioural queue model sets the expected ready, head, ninth-bit, framing and overrun values after every frame and every read.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int DATA_W = 8;

  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic clrShift;
    logic shiftEn;
    logic bitVal;
    logic push;
    logic stopVal;
  } rxStrobeT;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rxEntryT;
endpackage

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl
  import mdrop_rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             portEn,
  input  logic             rxEn,
  input  logic             nineBitMode,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       speedSel,
  output rxStrobeT         strb
);
  localparam int CNT_W = DIV_W + 5;
  localparam logic [3:0] VOTE_A = 4'd6;
  localparam logic [3:0] VOTE_B = 4'd7;
  localparam logic [3:0] VOTE_C = 4'd8;

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rxStateT;

  rxStateT          state;
  logic [1:0]       lineSync;
  logic             lineQ;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLim;
  logic [CNT_W-1:0] divPlus;
  logic             tick;
  logic [3:0]       phase;
  logic [3:0]       bitIdx;
  logic [3:0]       nBits;
  logic             samp0, samp1, vote, active, decide;

  assign lineQ  = lineSync[1];
  assign active = portEn && rxEn;
  assign nBits  = nineBitMode ? 4'd9 : 4'd8;

  always_comb begin
    divPlus = CNT_W'(divisor) + CNT_W'(1);
    unique case (speedSel)
      2'd0:    tickLim = (divPlus << 4) - CNT_W'(1);
      2'd1:    tickLim = (divPlus << 2) - CNT_W'(1);
      default: tickLim = divPlus - CNT_W'(1);
    endcase
  end

  assign tick   = (tickCnt == tickLim);
  assign vote   = (samp0 & samp1) | (samp0 & lineQ) | (samp1 & lineQ);
  assign decide = tick && (phase == VOTE_C) && (state != IDLE);

  always_comb begin
    strb          = '0;
    strb.clrShift = (state == IDLE) && active && !lineQ;
    strb.bitVal   = vote;
    strb.stopVal  = vote;
    strb.shiftEn  = decide && (state == DATA);
    strb.push     = decide && (state == STOP) && active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 2'b11;
    else       lineSync <= {lineSync[0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      tickCnt <= '0;
      phase   <= '0;
      bitIdx  <= '0;
      samp0   <= 1'b1;
      samp1   <= 1'b1;
    end else if (!active) begin
      state   <= IDLE;
      tickCnt <= '0;
    end else if (state == IDLE) begin
      tickCnt <= '0;
      if (!lineQ) begin
        state  <= START;
        phase  <= '0;
        bitIdx <= '0;
      end
    end else begin
      tickCnt <= tick ? '0 : tickCnt + CNT_W'(1);
      if (tick) begin
        phase <= phase + 4'd1;
        if (phase == VOTE_A) samp0 <= lineQ;
        if (phase == VOTE_B) samp1 <= lineQ;
        unique case (state)
          START: begin
            if (decide && vote)       state <= IDLE;
            else if (phase == 4'd15)  state <= DATA;
          end
          DATA: begin
            if (decide) bitIdx <= bitIdx + 4'd1;
            if (phase == 4'd15 && bitIdx == nBits) state <= STOP;
          end
          STOP:    if (decide) state <= IDLE;
          default: state <= IDLE;
        endcase
      end
    end
  end

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(portEn && rxEn) |=> state == IDLE);
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != IDLE && !tick && portEn && rxEn) |=> $stable(phase));
  // R2
  push_ends_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> state == IDLE);
endmodule

// File: rtl/mdrop_rx_dpath.sv
module mdrop_rx_dpath
  import mdrop_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  rxStrobeT strb,
  input  logic     rxEn,
  input  logic     nineBitMode,
  input  logic     addrDetEn,
  input  logic     rdStrobe,
  output rxEntryT  head,
  output logic     notEmpty,
  output logic     overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W:0]   shiftReg;
  rxEntryT           store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  rxEntryT           cand;
  logic              accept, doPush, doPop, full;

  always_comb begin
    cand.ferr = !strb.stopVal;
    if (nineBitMode) begin
      cand.bit9 = shiftReg[DATA_W];
      cand.data = shiftReg[DATA_W-1:0];
    end else begin
      cand.bit9 = 1'b0;
      cand.data = shiftReg[DATA_W:1];
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign notEmpty = (count != '0);
  assign accept   = strb.push && (!nineBitMode || !addrDetEn || cand.bit9);
  assign doPush   = accept && !overrun && !full;
  assign doPop    = rdStrobe && notEmpty;
  assign head     = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.clrShift) shiftReg <= '0;
    else if (strb.shiftEn)  shiftReg <= {strb.bitVal, shiftReg[DATA_W:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            overrun <= 1'b0;
    else if (!rxEn)                       overrun <= 1'b0;
    else if (accept && !overrun && full)  overrun <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (doPush) begin
        store[wrPtr] <= cand;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (doPop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && rxEn) |=> overrun);
  // R5
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && nineBitMode && addrDetEn && !shiftReg[DATA_W] && !rdStrobe)
      |=> count == $past(count));
  // R8
  locked_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && rxEn && !rdStrobe) |=> count == $past(count));
endmodule

// File: rtl/uart_mdrop_rx.sv
module uart_mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              portEn,
  input  logic              rxEn,
  input  logic              nineBitMode,
  input  logic              addrDetEn,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        speedSel,
  input  logic              irqEn,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit9,
  output logic              rdFerr,
  output logic              overrunErr,
  output logic              rxReady,
  output logic              irq
);
  rxStrobeT strb;
  rxEntryT  head;
  logic     notEmpty;

  mdrop_rx_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .portEn(portEn), .rxEn(rxEn),
    .nineBitMode(nineBitMode), .divisor(divisor), .speedSel(speedSel),
    .strb(strb)
  );

  mdrop_rx_dpath #(.DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxEn(rxEn),
    .nineBitMode(nineBitMode), .addrDetEn(addrDetEn), .rdStrobe(rdStrobe),
    .head(head), .notEmpty(notEmpty), .overrun(overrunErr)
  );

  assign rdData  = head.data;
  assign rdBit9  = head.bit9;
  assign rdFerr  = head.ferr;
  assign rxReady = notEmpty;
  assign irq     = notEmpty && irqEn;

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);
endmodule

// File: tb/sim_uart_mdrop_rx.sv
module sim_uart_mdrop_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       portEn = 1'b1, rxEn = 1'b1, nineBitMode = 1'b0, addrDetEn = 1'b0;
  logic [7:0] divisor = 8'd1;
  logic [1:0] speedSel = 2'd2;
  logic       irqEn = 1'b1, rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       rdBit9, rdFerr, overrunErr, rxReady, irq;

  int checks = 0, errors = 0, bitClk = 32;
  bit done = 0;
  int q[$];
  bit mOvr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mdrop_rx u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .portEn(portEn), .rxEn(rxEn),
    .nineBitMode(nineBitMode), .addrDetEn(addrDetEn), .divisor(divisor),
    .speedSel(speedSel), .irqEn(irqEn), .rdStrobe(rdStrobe), .rdData(rdData),
    .rdBit9(rdBit9), .rdFerr(rdFerr), .overrunErr(overrunErr),
    .rxReady(rxReady), .irq(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(string req);
    chk(req, "rxReady", int'(rxReady), int'(q.size() > 0));
    chk(req, "irq", int'(irq), int'(q.size() > 0 && irqEn));
    chk(req, "overrunErr", int'(overrunErr), int'(mOvr));
    if (q.size() > 0) begin
      chk(req, "rdData", int'(rdData), q[0] & 'hff);
      chk(req, "rdBit9", int'(rdBit9), (q[0] >> 8) & 1);
      chk(req, "rdFerr", int'(rdFerr), (q[0] >> 9) & 1);
    end
  endtask

  task automatic setSpeed(logic [1:0] sel, logic [7:0] dv);
    int m;
    @(negedge clk);
    speedSel = sel;
    divisor  = dv;
    m = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 4 : 1;
    bitClk = 16 * m * (int'(dv) + 1);
  endtask

  task automatic modelPush(int val, bit stopV);
    int nb = nineBitMode ? (val >> 8) & 1 : 0;
    if (!(portEn && rxEn)) return;
    if (nineBitMode && addrDetEn && nb == 0) return;
    if (mOvr) return;
    if (q.size() == 2) begin mOvr = 1; return; end
    q.push_back((int'(!stopV) << 9) | (nb << 8) | (val & 'hff));
  endtask

  task automatic sendFrame(int val, bit stopV = 1'b1);
    int nbits = nineBitMode ? 9 : 8;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (bitClk) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxLine = (val >> i) & 1;
      repeat (bitClk) @(negedge clk);
    end
    rxLine = stopV;
    repeat (bitClk) @(negedge clk);
    rxLine = 1'b1;
    repeat (bitClk) @(negedge clk);
    modelPush(val, stopV);
  endtask

  task automatic readOne();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    sendFrame('hA5);  checkState("R2");
    readOne();        checkState("R7");

    setSpeed(2'd1, 8'd0);
    sendFrame('h3C);  checkState("R3");
    readOne();
    setSpeed(2'd0, 8'd0);
    sendFrame('h81);  checkState("R3");
    readOne();
    setSpeed(2'd2, 8'd1);

    irqEn = 1'b0;
    sendFrame('h55);  checkState("R10");
    irqEn = 1'b1;
    @(negedge clk);   checkState("R10");
    readOne();

    sendFrame('h0F, 1'b0); checkState("R6");
    readOne();             checkState("R6");

    // R11: short low glitch must not produce a character
    @(negedge clk);
    rxLine = 1'b0;
    repeat (6) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * bitClk) @(negedge clk);
    checkState("R11");
    sendFrame('h5A);  checkState("R11");
    readOne();

    nineBitMode = 1'b1;
    sendFrame('h1C3); checkState("R4");
    readOne();
    sendFrame('h042); checkState("R4");
    readOne();

    addrDetEn = 1'b1;
    sendFrame('h077); checkState("R5");
    sendFrame('h1AB); checkState("R5");
    readOne();
    addrDetEn = 1'b0;
    sendFrame('h011); checkState("R5");
    readOne();
    nineBitMode = 1'b0;

    sendFrame('h11);
    sendFrame('h22);  checkState("R7");
    sendFrame('h33);  checkState("R8");
    readOne();        checkState("R8");
    readOne();        checkState("R7");
    sendFrame('h44);  checkState("R8");
    @(negedge clk);
    rxEn = 1'b0;
    mOvr = 0;
    @(negedge clk);
    checkState("R9");
    rxEn = 1'b1;
    sendFrame('h55);  checkState("R9");
    readOne();

    rxEn = 1'b0;
    sendFrame('h66);  checkState("R9");
    rxEn = 1'b1;
    portEn = 1'b0;
    sendFrame('h67);  checkState("R9");
    portEn = 1'b1;
    sendFrame('h68);  checkState("R9");
    readOne();        checkState("R7");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule